// File: doc/BRIEF.md
# Wrapped Burst Read Address Generator

This block supplies the byte address for each data beat of a serial flash read. A set-burst-with-wrap configuration byte is captured first. It holds a wrap-disable bit and a two-bit window code. Each read then begins with a start strobe that carries a 21-bit byte address and a flag that marks the read as a quad I/O fast read. After that, every beat strobe moves the address on by one byte.

When wrapping is enabled and the read is quad I/O, the address stays inside an aligned window of 8, 16, 32 or 64 bytes. The low bits count modulo the window size and the high bits hold. For any other read the address counts linearly through the whole 2 MiB array and rolls from the top back to zero.

The mode and the window are fixed when the read starts. A configuration byte that arrives during a read takes effect from the next start. All pins are plain strobes and levels. No data stream passes through the block, so it has no back-pressure.

Top module: `burst_wrap_addr_gen`

## Requirements
- R1: While reset is asserted and afterwards until the first strobe, `addr_o` is 0 and `wrap_active_o` is 0. The stored configuration resets to wrap disabled with window code 00.
- R2: A `cfg_valid` pulse captures `cfg_data[4]` as wrap-disable (1 = wrap off, 0 = wrap on) and `cfg_data[6:5]` as the window code: 00=8, 01=16, 10=32, 11=64 bytes. Bits 7 and 3:0 are ignored.
- R3: A `rd_start` pulse loads `rd_addr` into `addr_o` one cycle later. If `beat` is high in the same cycle, `rd_start` wins.
- R4: At a read start, `wrap_active_o` becomes 1 only if `rd_quad` is 1 and the stored wrap-disable bit is 0. Otherwise it becomes 0.
- R5: While `wrap_active_o` is 1, each beat increments the low log2(window) address bits modulo the window size and leaves the upper bits unchanged.
- R6: While `wrap_active_o` is 0, each beat adds one to `addr_o`, and 1FFFFFh is followed by 000000h.
- R7: In a cycle with neither `rd_start` nor `beat`, `addr_o` and `wrap_active_o` hold their values.
- R8: The mode and window in force are those stored when `rd_start` was seen. A `cfg_valid` during a read changes neither until the next `rd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Capture the wrap configuration byte |
| cfg_data | input | 8 | Configuration byte; bit 4 is wrap-disable, bits 6:5 are the window code |
| rd_start | input | 1 | Begin a read at `rd_addr` |
| rd_addr | input | 21 | Start byte address |
| rd_quad | input | 1 | The read being started is a quad I/O fast read |
| beat | input | 1 | Advance one byte |
| addr_o | output | 21 | Current byte address |
| wrap_active_o | output | 1 | The current read wraps inside its window |

## Verification
Every result is registered once. `addr_o` and `wrap_active_o` reflect a start, a beat or an idle cycle on the first rising edge after the strobe. A configuration byte first shows through the next read start.

The bench drives each strobe for one cycle from the falling edge. It then compares the outputs at the next falling edge, half a period after the edge that updates them. It computes the expected address from the window arithmetic stated in R5 and R6.

// File: rtl/burst_wrap_pkg.sv
package burst_wrap_pkg;
  localparam int ADDR_W       = 21;
  localparam int WSEL_W       = 2;
  localparam int MIN_WIN_LOG2 = 3;
  localparam int CFG_W        = 8;
  localparam int OFF_BIT      = 4;
  localparam int SEL_LSB      = 5;

  typedef struct packed {
    logic              wrap_off;
    logic [WSEL_W-1:0] win_sel;
  } wrap_cfg_t;
endpackage

// File: rtl/bw_cfg_reg.sv
module bw_cfg_reg
  import burst_wrap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [CFG_W-1:0] cfg_data,
  output wrap_cfg_t        cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.wrap_off <= 1'b1;
      cfg_q.win_sel  <= '0;
    end else if (cfg_valid) begin
      cfg_q.wrap_off <= cfg_data[OFF_BIT];
      cfg_q.win_sel  <= cfg_data[SEL_LSB +: WSEL_W];
    end
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_q.wrap_off == $past(cfg_data[OFF_BIT])) &&
                  (cfg_q.win_sel  == $past(cfg_data[SEL_LSB +: WSEL_W])));
endmodule

// File: rtl/bw_win_mask.sv
module bw_win_mask #(
  parameter int ADDR_W       = 21,
  parameter int WSEL_W       = 2,
  parameter int MIN_WIN_LOG2 = 3
) (
  input  logic [WSEL_W-1:0] sel,
  output logic [ADDR_W-1:0] mask
);
  localparam int NUM_WIN = 1 << WSEL_W;

  logic [ADDR_W-1:0] masks [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam int LOG2 = MIN_WIN_LOG2 + i;
    assign masks[i] = (ADDR_W'(1) << LOG2) - ADDR_W'(1);
  end

  assign mask = masks[sel];
endmodule

// File: rtl/bw_addr_step.sv
module bw_addr_step #(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] mask,
  input  logic              wrap,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] hold_mask;

  always_comb begin
    inc       = cur + ADDR_W'(1);
    hold_mask = wrap ? ~mask : '0;
    nxt       = (cur & hold_mask) | (inc & ~hold_mask);
  end
endmodule

// File: rtl/burst_wrap_addr_gen.sv
module burst_wrap_addr_gen
  import burst_wrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_quad,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_active_o
);
  localparam logic [ADDR_W-1:0] RST_MASK = (ADDR_W'(1) << MIN_WIN_LOG2) - ADDR_W'(1);

  wrap_cfg_t         cfg_q;
  logic [ADDR_W-1:0] cfg_mask;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] step_addr;

  bw_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_data (cfg_data),
    .cfg_q    (cfg_q)
  );

  bw_win_mask #(
    .ADDR_W      (ADDR_W),
    .WSEL_W      (WSEL_W),
    .MIN_WIN_LOG2(MIN_WIN_LOG2)
  ) u_mask (
    .sel (cfg_q.win_sel),
    .mask(cfg_mask)
  );

  bw_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur (addr_o),
    .mask(mask_q),
    .wrap(wrap_active_o),
    .nxt (step_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o        <= '0;
      wrap_active_o <= 1'b0;
      mask_q        <= RST_MASK;
    end else if (rd_start) begin
      addr_o        <= rd_addr;
      wrap_active_o <= rd_quad & ~cfg_q.wrap_off;
      mask_q        <= cfg_mask;
    end else if (beat) begin
      addr_o        <= step_addr;
    end
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> addr_o == $past(rd_addr));

  // R4
  mode_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> wrap_active_o == $past(rd_quad && !cfg_q.wrap_off));

  // R5
  wrap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !rd_start && wrap_active_o) |=>
      ((addr_o & ~$past(mask_q)) == ($past(addr_o) & ~$past(mask_q))) &&
      (addr_o != $past(addr_o)));

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !rd_start && !wrap_active_o) |=>
      addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !rd_start) |=> $stable(addr_o) && $stable(wrap_active_o));

  // R8
  window_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(mask_q) && $stable(wrap_active_o));
endmodule

// File: tb/burst_wrap_addr_gen_tb.sv
module burst_wrap_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        rd_start = 1'b0;
  logic [20:0] rd_addr = '0;
  logic        rd_quad = 1'b0;
  logic        beat = 1'b0;
  logic [20:0] addr_o;
  logic        wrap_active_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_wrap_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_quad(rd_quad), .beat(beat),
    .addr_o(addr_o), .wrap_active_o(wrap_active_o)
  );

  function automatic logic [20:0] next_exp(input logic [20:0] a, input bit w,
                                           input logic [1:0] s);
    logic [20:0] m;
    m = (21'd8 << s) - 21'd1;
    if (!w) return a + 21'd1;
    return (a & ~m) | ((a + 21'd1) & m);
  endfunction

  task automatic chk(input string tag, input logic [20:0] exp_a, input bit exp_w);
    checks++;
    if (addr_o !== exp_a || wrap_active_o !== exp_w) begin
      errors++;
      $display("FAIL %s: addr=%h wrap=%0b expected addr=%h wrap=%0b",
               tag, addr_o, wrap_active_o, exp_a, exp_w);
    end
  endtask

  task automatic do_cfg(input logic [7:0] b);
    cfg_valid = 1'b1; cfg_data = b;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_data = '0;
  endtask

  task automatic do_start(input logic [20:0] a, input bit q, input bit with_beat);
    rd_start = 1'b1; rd_addr = a; rd_quad = q; beat = with_beat;
    @(negedge clk);
    rd_start = 1'b0; rd_quad = 1'b0; beat = 1'b0;
  endtask

  task automatic do_beat();
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
  endtask

  task automatic run_beats(input string tag, input logic [20:0] a0, input int n,
                           input bit w, input logic [1:0] s);
    logic [20:0] e;
    e = a0;
    for (int i = 0; i < n; i++) begin
      do_beat();
      e = next_exp(e, w, s);
      chk(tag, e, w);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset", 21'h0, 1'b0);
    do_start(21'h000123, 1'b1, 1'b0);
    chk("R1 wrap off after reset", 21'h000123, 1'b0);
  endtask

  task automatic t_sequential();
    do_start(21'h000010, 1'b0, 1'b0);
    chk("R3 start load", 21'h000010, 1'b0);
    run_beats("R6 linear", 21'h000010, 12, 1'b0, 2'd0);
    do_start(21'h1FFFFE, 1'b0, 1'b0);
    run_beats("R6 top rollover", 21'h1FFFFE, 3, 1'b0, 2'd0);
  endtask

  task automatic t_wrap_windows();
    logic [20:0] a;
    for (int s = 0; s < 4; s++) begin
      do_cfg({1'b0, 2'(s), 1'b0, 4'h0});
      a = 21'h0ABC00 | 21'((8 << s) - 3);
      do_start(a, 1'b1, 1'b0);
      chk("R4 wrap on quad", a, 1'b1);
      run_beats("R5 wrap window", a, (8 << s) + 4, 1'b1, 2'(s));
    end
  endtask

  task automatic t_wrap_gating();
    do_cfg(8'h20);
    do_start(21'h00001E, 1'b0, 1'b0);
    chk("R4 non-quad linear", 21'h00001E, 1'b0);
    run_beats("R4 non-quad linear", 21'h00001E, 4, 1'b0, 2'd1);
    do_cfg(8'h30);
    do_start(21'h00001E, 1'b1, 1'b0);
    chk("R2 disable bit set", 21'h00001E, 1'b0);
    run_beats("R2 disable bit linear", 21'h00001E, 4, 1'b0, 2'd1);
  endtask

  task automatic t_ignored_bits();
    do_cfg(8'h8F);
    do_start(21'h000106, 1'b1, 1'b0);
    chk("R2 ignored bits", 21'h000106, 1'b1);
    run_beats("R2 ignored bits 8-byte", 21'h000106, 3, 1'b1, 2'd0);
  endtask

  task automatic t_midread_cfg();
    do_cfg(8'h00);
    do_start(21'h001006, 1'b1, 1'b0);
    do_cfg(8'h70);
    chk("R8 cfg mid-read", 21'h001006, 1'b1);
    run_beats("R8 old window kept", 21'h001006, 4, 1'b1, 2'd0);
    do_start(21'h001006, 1'b1, 1'b0);
    chk("R8 new cfg at next start", 21'h001006, 1'b0);
  endtask

  task automatic t_priority_hold();
    do_start(21'h000050, 1'b0, 1'b0);
    do_start(21'h000200, 1'b0, 1'b1);
    chk("R3 start beats beat", 21'h000200, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 idle hold", 21'h000200, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 21'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_wrap_windows();
    t_wrap_gating();
    t_ignored_bits();
    t_midread_cfg();
    t_priority_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule